// File: doc/BRIEF.md
# Submission Queue Doorbell Tracker

This block tracks one circular submission queue on the controller side. The host places commands in queue slots and then writes an absolute tail index to a doorbell port. That index is not a count. The block derives the number of newly posted commands as the modular distance from the tail it held before. It then asks for those slots one at a time, oldest first, over a valid/ready fetch interface.

Each accepted fetch moves an internal head pointer forward by one, wrapping from the last slot to slot zero. The current head is exported so that the completion path can report how far the queue has been consumed. A single write may post one command or many.

A doorbell write is rejected when its index lies outside the queue, or when it would move the tail past entries that have not yet been consumed. A rejected write leaves the tail unchanged and sets an error flag that stays set until reset. One slot is always kept free, so the queue holds at most DEPTH-1 commands.

Top module: `sq_doorbell_tracker`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears head, tail and the error flag to zero. After reset, fetch_valid is 0 and head_out is 0.
- R2: When a write of tail index v (v < DEPTH) is accepted, (v - old tail) mod DEPTH new slots become pending. fetch_valid is 1 from the cycle after the write for as long as pending slots remain.
- R3: fetch_slot shows the current head. Slots are issued in ascending order and wrap from DEPTH-1 to 0.
- R4: The head advances only in a cycle where fetch_valid and fetch_ready are both 1. While fetch_valid is 1 and fetch_ready is 0, fetch_slot holds steady.
- R5: head_out equals the number of accepted fetches since reset, modulo DEPTH.
- R6: A doorbell value of DEPTH or more is ignored, so no new slots are issued. It sets db_err from the next cycle.
- R7: A doorbell write whose distance from the head, (v - head) mod DEPTH, is smaller than the current occupancy (tail - head) mod DEPTH would overrun unconsumed entries. Such a write is ignored and sets db_err.
- R8: Writing the current tail value again is valid. It posts nothing and does not set db_err.
- R9: db_err stays 1 until reset. Valid doorbell writes are still accepted while it is set.
- R10: A doorbell write and a fetch acceptance in the same cycle both take effect. The validity check uses the head as it was before that edge.
- R11: A write that brings the occupancy to DEPTH-1 is valid, and all DEPTH-1 slots are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| db_wr | input | 1 | Doorbell write strobe |
| db_tail | input | IW | Absolute tail index written by the host |
| fetch_valid | output | 1 | A slot is pending fetch |
| fetch_slot | output | IW | Index of the slot to fetch |
| fetch_ready | input | 1 | Downstream accepts the fetch this cycle |
| head_out | output | IW | Consumed head for completion reporting |
| db_err | output | 1 | Sticky invalid-doorbell flag |

## Verification
Every result is due one clock edge after its cause. A doorbell write at an edge shows up in fetch_valid and db_err one cycle later. An accepted fetch at an edge moves fetch_slot and head_out at that same edge. The bench therefore drives inputs on the falling edge, updates its reference model as if the next rising edge had already happened, and compares all outputs at the following falling edge. Directed steps cover a full queue, overrun, out-of-range and repeated-tail writes, and a write that coincides with a fetch. Seeded random writes, random ready and occasional resets fill in the rest.

// File: rtl/sq_doorbell_tracker.sv
module sq_doorbell_tracker #(
  parameter int DEPTH = 12,
  localparam int IW = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          db_wr,
  input  logic [IW-1:0] db_tail,
  output logic          fetch_valid,
  output logic [IW-1:0] fetch_slot,
  input  logic          fetch_ready,
  output logic [IW-1:0] head_out,
  output logic          db_err
);

  localparam logic [IW:0] DEP  = DEPTH[IW:0];
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [IW-1:0] head_q, tail_q;
  logic          err_q;
  logic [IW-1:0] occ, span;
  logic          in_range, db_ok, accept;

  function automatic logic [IW-1:0] mdiff(input logic [IW-1:0] a, input logic [IW-1:0] b);
    logic [IW:0] t;
    t = {1'b0, a} - {1'b0, b};
    if (a < b) t = t + DEP;
    return t[IW-1:0];
  endfunction

  assign occ      = mdiff(tail_q, head_q);
  assign span     = mdiff(db_tail, head_q);
  assign in_range = ({1'b0, db_tail} < DEP);
  assign db_ok    = in_range && (span >= occ);

  assign fetch_valid = (head_q != tail_q);
  assign fetch_slot  = head_q;
  assign head_out    = head_q;
  assign db_err      = err_q;
  assign accept      = fetch_valid & fetch_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (db_wr) begin
        if (db_ok) tail_q <= db_tail;
        else       err_q  <= 1'b1;
      end
      if (accept) head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !fetch_valid && head_out == '0 && !db_err);

  p_head_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(fetch_valid && fetch_ready) |=> $stable(head_out));

  p_slot_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_ready) |=> fetch_valid && $stable(fetch_slot));

  p_head_step_r3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_ready) |=>
      head_out == (($past(head_out) == LAST) ? '0 : $past(head_out) + 1'b1));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst) db_err |=> db_err);

  p_bad_index_r6: assert property (@(posedge clk) disable iff (rst)
    (db_wr && !in_range) |=> db_err && $stable(tail_q));

  p_ptr_range_r3: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, head_q} < DEP) && ({1'b0, tail_q} < DEP));

endmodule

// File: tb/test_sq_doorbell_tracker.sv
`timescale 1ns/1ps
module test_sq_doorbell_tracker;
  localparam int DEPTH = 12;
  localparam int IW = $clog2(DEPTH);

  logic clk = 0, rst = 1, db_wr = 0, fetch_ready = 0;
  logic [IW-1:0] db_tail = '0;
  logic fetch_valid, db_err;
  logic [IW-1:0] fetch_slot, head_out;

  int n_chk = 0, n_fail = 0;
  int mh = 0, mt = 0;
  bit merr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sq_doorbell_tracker #(.DEPTH(DEPTH)) i_sq_doorbell_tracker (
    .clk(clk), .rst(rst), .db_wr(db_wr), .db_tail(db_tail),
    .fetch_valid(fetch_valid), .fetch_slot(fetch_slot), .fetch_ready(fetch_ready),
    .head_out(head_out), .db_err(db_err));

  function automatic int md(int a, int b);
    return (a - b + DEPTH) % DEPTH;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit w, int v, bit r, bit rs, string req);
    bit acc;
    db_wr = w; db_tail = IW'(v); fetch_ready = r; rst = rs;
    if (rs) begin
      mh = 0; mt = 0; merr = 0;
    end else begin
      acc = (mh != mt) && r;
      if (w) begin
        if (v >= DEPTH || md(v, mh) < md(mt, mh)) merr = 1;
        else mt = v;
      end
      if (acc) mh = (mh + 1) % DEPTH;
    end
    @(negedge clk);
    chk(req, "R2 fetch_valid", int'(fetch_valid), int'(mh != mt));
    if (mh != mt) chk(req, "R3 fetch_slot", int'(fetch_slot), mh);
    chk(req, "R5 head_out", int'(head_out), mh);
    chk(req, "R6/R7 db_err", int'(db_err), int'(merr));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    cyc(0, 0, 0, 1, "R1");
    cyc(0, 0, 1, 0, "R1");
    cyc(1, 5, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, "R4");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, "R3");
    cyc(1, 5, 1, 0, "R8");
    cyc(1, 4, 0, 0, "R11");
    cyc(1, 5, 0, 0, "R7");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, "R11");
    cyc(1, 7, 1, 0, "R10");
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 0, "R3");
    cyc(0, 0, 0, 1, "R9");
    cyc(1, 13, 1, 0, "R6");
    cyc(1, 15, 1, 0, "R6");
    cyc(1, 11, 0, 0, "R9");
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 0, "R3");
    for (int i = 0; i < 3000; i++) begin
      bit w = ($urandom_range(0, 3) == 0);
      int v;
      if ($urandom_range(0, 1) == 0) v = (mt + $urandom_range(0, DEPTH - 1 - md(mt, mh))) % DEPTH;
      else v = $urandom_range(0, 15);
      cyc(w, v, $urandom_range(0, 2) != 0, $urandom_range(0, 499) == 0, "R10");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule